// File: doc/BRIEF.md
# Peripheral Dual-Domain Clock Selector

This block produces the two clock enables for a serial-bus peripheral that is split into two clock domains. The storage domain, which holds message data, is always clocked from the system clock. The line-interface domain is clocked from either the system clock or an external crystal oscillator. A single source bit chooses between them. A disable bit turns off both enables. All logic runs on the system clock. The oscillator is brought in through a synchronizer and an edge detector, so in oscillator mode the interface enable is a one-cycle pulse for each oscillator edge.

Software changes these settings through a small write port that carries the source bit, the disable bit and an error-clear bit. A change of source is accepted only while the module is disabled. A write that tries to change the source while the module is enabled leaves the source as it was and sets a sticky error flag. An accepted change runs a break-before-make switchover: the interface enable stays off until a programmable number of system cycles and a programmable number of oscillator edges have passed. A busy flag reports that the switchover is in progress. An enable written during the switchover is held back until the switchover completes. A separate configuration-error output warns when the oscillator source is selected while an external indication says the oscillator runs faster than the system clock.

Top module: `pdcs_clk_sel`

## Requirements
- R1: After reset the module is disabled, the source is the system clock (`sel_stat` = 0), and `msg_ce`, `if_ce`, `busy` and `wr_err` are all 0.
- R2: `msg_ce` is 1 on every system cycle while the module is enabled and 0 while it is disabled. `if_ce` is never 1 while `msg_ce` is 0.
- R3: While the module is enabled with the system source (`sel_stat` = 0), `if_ce` is 1 on every system cycle.
- R4: While the module is enabled with the oscillator source (`sel_stat` = 1), `if_ce` pulses for exactly one system cycle per rising edge of `osc_clk`. Two pulses are never in adjacent cycles.
- R5: A write whose `wr_sel` differs from `sel_stat`, made while the module is enabled, leaves `sel_stat` unchanged and sets `wr_err`. This holds even if the same write also sets `wr_dis`.
- R6: `wr_err` stays set until a write with `wr_clr_err` = 1. If that write is itself a rejected source change, the flag stays set.
- R7: A source change written while the module is disabled updates `sel_stat` and raises `busy` at the next edge. `busy` falls only after at least GAP_CYCLES system cycles and GAP_CYCLES rising `osc_clk` edges have passed (default 2).
- R8: A write with `wr_dis` = 0 made while `busy` is 1, or together with an accepted source change, leaves `msg_ce` at 0 until `busy` falls. `msg_ce` then becomes 1 in the same cycle that `busy` falls.
- R9: `cfg_err` is 1 exactly when `osc_fast` is 1 and `sel_stat` = 1.
- R10: A write with `wr_dis` = 1 drives `msg_ce` and `if_ce` to 0 from the next cycle, and it cancels any enable that is being held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| osc_clk | input | 1 | Crystal oscillator clock, asynchronous to clk |
| osc_fast | input | 1 | External indication that the oscillator is faster than clk |
| wr_en | input | 1 | Control write strobe |
| wr_sel | input | 1 | Written source: 0 system, 1 oscillator |
| wr_dis | input | 1 | Written disable bit: 1 disables the module |
| wr_clr_err | input | 1 | Written error-clear bit |
| msg_ce | output | 1 | Storage-domain clock enable |
| if_ce | output | 1 | Interface-domain clock enable |
| sel_stat | output | 1 | Currently selected source |
| busy | output | 1 | Source switchover in progress |
| wr_err | output | 1 | Sticky flag for a rejected source change |
| cfg_err | output | 1 | Oscillator selected while flagged faster than clk |

## Verification
The hardest situation to reach is a held-back enable that is later cancelled. To build it, the module must first be disabled, then a source change must start a switchover, then an enable must arrive while `busy` is high, and then a disable must arrive before the slow oscillator has produced enough edges. The stimulus gets there by setting the oscillator period to ten system cycles, which leaves a window of about twenty cycles. It then issues three back-to-back writes inside that window and checks that `msg_ce` stays low after `busy` falls. The vector table also covers writes that both disable the module and change the source, because the rejection depends on the disable state before the write and not after it.

// File: rtl/pdcs_pkg.sv
`timescale 1ns/1ps
package pdcs_pkg;
   typedef enum logic {
      SRC_SYS = 1'b0,
      SRC_OSC = 1'b1
   } src_e;

   typedef enum logic {
      SW_RUN   = 1'b0,
      SW_BREAK = 1'b1
   } sw_e;
endpackage

// File: rtl/pdcs_osc_sync.sv
`timescale 1ns/1ps
module pdcs_osc_sync #(
   parameter int STAGES  = 2,
   parameter bit ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_clk,
   output logic osc_tick
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pdcs_osc_sync: STAGES must be at least 2");
      end
   endgenerate

   // Synchronizer chain, one flop per stage.
   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= osc_clk;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];
   end

   // Edge polarity chosen at elaboration.
   generate
      if (ON_RISE) begin : g_rise
         assign osc_tick = sync_q[LAST] & ~prev_q;
      end else begin : g_fall
         assign osc_tick = ~sync_q[LAST] & prev_q;
      end
   endgenerate

   // R4: an edge pulse never lasts two cycles
   a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      osc_tick |=> !osc_tick);
endmodule

// File: rtl/pdcs_switch_fsm.sv
`timescale 1ns/1ps
module pdcs_switch_fsm
   import pdcs_pkg::*;
#(
   parameter int GAP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  src_e tgt_src,
   input  logic osc_tick,
   output logic busy,
   output logic done,
   output src_e act_src
);
   localparam int            CW    = $clog2(GAP + 1);
   localparam logic [CW-1:0] GAP_C = CW'(GAP);

   sw_e           state_q;
   logic [CW-1:0] sys_cnt_q;
   logic [CW-1:0] osc_cnt_q;

   generate
      if (GAP < 2) begin : g_bad_gap
         $error("pdcs_switch_fsm: GAP must be at least 2");
      end
   endgenerate

   assign busy = (state_q == SW_BREAK);
   assign done = busy && !start && (sys_cnt_q == GAP_C) && (osc_cnt_q == GAP_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SW_RUN;
         sys_cnt_q <= '0;
         osc_cnt_q <= '0;
         act_src   <= SRC_SYS;
      end else if (start) begin
         state_q   <= SW_BREAK;
         sys_cnt_q <= '0;
         osc_cnt_q <= '0;
      end else if (state_q == SW_BREAK) begin
         if (done) begin
            state_q <= SW_RUN;
            act_src <= tgt_src;
         end else begin
            if (sys_cnt_q != GAP_C) sys_cnt_q <= sys_cnt_q + 1'b1;
            if (osc_tick && (osc_cnt_q != GAP_C)) osc_cnt_q <= osc_cnt_q + 1'b1;
         end
      end
   end

   // R7: a switchover lasts more than one cycle
   a_r7_break_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);
   // R7: the active source moves only when a switchover completes
   a_r7_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(act_src));
endmodule

// File: rtl/pdcs_cfg_regs.sv
`timescale 1ns/1ps
module pdcs_cfg_regs
   import pdcs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_sel,
   input  logic wr_dis,
   input  logic wr_clr_err,
   input  logic busy,
   input  logic done,
   output src_e sel_q,
   output logic dis_q,
   output logic start,
   output logic err_q
);
   logic pend_q;
   logic sel_diff;
   logic reject;
   logic defer;

   assign sel_diff = wr_en && (src_e'(wr_sel) != sel_q);
   assign start    = sel_diff && dis_q;
   assign reject   = sel_diff && !dis_q;
   assign defer    = start || (busy && !done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SRC_SYS;
      end else if (start) begin
         sel_q <= src_e'(wr_sel);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q  <= 1'b1;
         pend_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_dis) begin
            dis_q  <= 1'b1;
            pend_q <= 1'b0;
         end else if (defer) begin
            pend_q <= 1'b1;
         end else begin
            dis_q  <= 1'b0;
            pend_q <= 1'b0;
         end
      end else if (done && pend_q) begin
         dis_q  <= 1'b0;
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    err_q <= 1'b0;
      else if (reject)               err_q <= 1'b1;
      else if (wr_en && wr_clr_err)  err_q <= 1'b0;
   end

   // R5: a source change while enabled keeps the source and flags
   a_r5_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !dis_q && (src_e'(wr_sel) != sel_q)) |=> ($stable(sel_q) && err_q));
   // R6: the error flag holds without a clear
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(wr_en && wr_clr_err)) |=> err_q);
   // R10: a disable write takes effect at the next edge
   a_r10_dis_now: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_dis) |=> dis_q);
endmodule

// File: rtl/pdcs_clk_sel.sv
`timescale 1ns/1ps
module pdcs_clk_sel
   import pdcs_pkg::*;
#(
   parameter int GAP_CYCLES   = 2,
   parameter int SYNC_STAGES  = 2,
   parameter bit TICK_ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_clk,
   input  logic osc_fast,
   input  logic wr_en,
   input  logic wr_sel,
   input  logic wr_dis,
   input  logic wr_clr_err,
   output logic msg_ce,
   output logic if_ce,
   output logic sel_stat,
   output logic busy,
   output logic wr_err,
   output logic cfg_err
);
   logic osc_tick;
   logic sw_start;
   logic sw_done;
   logic dis_q;
   src_e sel_q;
   src_e act_src;
   logic src_ce;

   generate
      if (GAP_CYCLES < 2) begin : g_bad_gap
         $error("pdcs_clk_sel: GAP_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pdcs_clk_sel: SYNC_STAGES must be at least 2");
      end
   endgenerate

   pdcs_osc_sync #(.STAGES(SYNC_STAGES), .ON_RISE(TICK_ON_RISE)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_clk  (osc_clk),
      .osc_tick (osc_tick)
   );

   pdcs_cfg_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_dis     (wr_dis),
      .wr_clr_err (wr_clr_err),
      .busy       (busy),
      .done       (sw_done),
      .sel_q      (sel_q),
      .dis_q      (dis_q),
      .start      (sw_start),
      .err_q      (wr_err)
   );

   pdcs_switch_fsm #(.GAP(GAP_CYCLES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (sw_start),
      .tgt_src  (sel_q),
      .osc_tick (osc_tick),
      .busy     (busy),
      .done     (sw_done),
      .act_src  (act_src)
   );

   assign src_ce   = (act_src == SRC_OSC) ? osc_tick : 1'b1;
   assign msg_ce   = !dis_q;
   assign if_ce    = !dis_q && !busy && src_ce;
   assign sel_stat = sel_q;
   assign cfg_err  = osc_fast && (sel_q == SRC_OSC);

   // R8: nothing is enabled while a switchover runs
   a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !msg_ce);
   // R2: the interface enable needs the module enabled
   a_r2_if_gated: assert property (@(posedge clk) disable iff (!rst_n)
      if_ce |-> msg_ce);
   // R3: system source runs the interface enable continuously
   a_r3_sys_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_ce && !sel_stat) |-> if_ce);
endmodule

// File: tb/pdcs_clk_sel_bench.sv
`timescale 1ns/1ps
module pdcs_clk_sel_bench;
   logic clk = 1'b0;
   logic osc_clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc_fast = 1'b0;
   logic wr_en = 1'b0;
   logic wr_sel = 1'b0;
   logic wr_dis = 1'b0;
   logic wr_clr_err = 1'b0;
   logic msg_ce, if_ce, sel_stat, busy, wr_err, cfg_err;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;        // 250 MHz
   always #20 osc_clk = ~osc_clk; // ten system cycles per oscillator period

   pdcs_clk_sel u_pdcs_clk_sel (
      .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .osc_fast(osc_fast),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_dis(wr_dis), .wr_clr_err(wr_clr_err),
      .msg_ce(msg_ce), .if_ce(if_ce), .sel_stat(sel_stat), .busy(busy),
      .wr_err(wr_err), .cfg_err(cfg_err)
   );

   // {wr_sel, wr_dis, wr_clr_err, exp_sel, exp_msg, exp_err}
   localparam logic [5:0] VEC [10] = '{
      6'b000010, 6'b100011, 6'b001010, 6'b110001, 6'b111100,
      6'b100110, 6'b000111, 6'b011101, 6'b001010, 6'b010000
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_write(input logic s, input logic d, input logic c);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_dis = d; wr_clr_err = c;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 1'b0; wr_dis = 1'b0; wr_clr_err = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      int bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(msg_ce == 0, "R1 msg_ce", msg_ce, 0);
      check(if_ce == 0, "R1 if_ce", if_ce, 0);
      check(sel_stat == 0, "R1 sel_stat", sel_stat, 0);
      check(busy == 0, "R1 busy", busy, 0);
      check(wr_err == 0, "R1 wr_err", wr_err, 0);

      // Vector table: R2/R5/R6/R7/R8 write sequences
      for (int v = 0; v < 10; v++) begin
         do_write(VEC[v][5], VEC[v][4], VEC[v][3]);
         wait_idle();
         check(sel_stat == VEC[v][2], $sformatf("R5/R7 vec %0d sel", v), sel_stat, VEC[v][2]);
         check(msg_ce == VEC[v][1], $sformatf("R2/R8 vec %0d msg", v), msg_ce, VEC[v][1]);
         check(wr_err == VEC[v][0], $sformatf("R5/R6 vec %0d err", v), wr_err, VEC[v][0]);
      end

      // R7: accepted change while disabled, busy duration
      do_write(1'b1, 1'b1, 1'b0);
      check(busy == 1, "R7 busy raised", busy, 1);
      n = 0;
      while (busy && n < 200) begin n++; @(negedge clk); end
      check(n >= 10 && n < 200, "R7 busy cycles", n, 10);
      check(sel_stat == 1, "R7 sel after switch", sel_stat, 1);

      // R8: enable written together with a source change is held back
      do_write(1'b0, 1'b0, 1'b0);
      bad = 0;
      while (busy) begin
         if (msg_ce) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R8 msg_ce during busy", bad, 0);
      check(msg_ce == 1, "R8 enabled after busy", msg_ce, 1);

      // R3: system source, enable every cycle
      n = 0;
      for (int i = 0; i < 20; i++) begin
         if (if_ce) n++;
         @(negedge clk);
      end
      check(n == 20, "R3 if_ce count", n, 20);
      osc_fast = 1'b1;
      #1;
      check(cfg_err == 0, "R9 cfg_err with system source", cfg_err, 0);
      osc_fast = 1'b0;

      // R10: disable gates at once, cancels a held-back enable
      do_write(1'b0, 1'b1, 1'b0);
      check(msg_ce == 0 && if_ce == 0, "R10 gated next cycle", msg_ce | if_ce, 0);
      do_write(1'b1, 1'b1, 1'b0);
      do_write(1'b1, 1'b0, 1'b0);
      do_write(1'b1, 1'b1, 1'b0);
      wait_idle();
      repeat (2) @(negedge clk);
      check(msg_ce == 0, "R10 cancelled enable", msg_ce, 0);

      // R9: oscillator selected and flagged faster
      osc_fast = 1'b1;
      #1;
      check(cfg_err == 1, "R9 cfg_err set", cfg_err, 1);
      osc_fast = 1'b0;
      #1;
      check(cfg_err == 0, "R9 cfg_err clear", cfg_err, 0);

      // R4: oscillator source pulse rate and width
      do_write(1'b1, 1'b0, 1'b0);
      n = 0;
      bad = 0;
      for (int i = 0; i < 200; i++) begin
         if (if_ce) begin
            n++;
            @(negedge clk);
            if (if_ce) bad++;
         end else begin
            @(negedge clk);
         end
      end
      check(n >= 19 && n <= 21, "R4 pulse count", n, 20);
      check(bad == 0, "R4 pulse width", bad, 0);

      // R2: disabled, no interface enable
      do_write(1'b1, 1'b1, 1'b0);
      n = 0;
      for (int i = 0; i < 30; i++) begin
         if (if_ce || msg_ce) n++;
         @(negedge clk);
      end
      check(n == 0, "R2 disabled enables", n, 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule